// File: doc/BRIEF.md
# Predecoded Row Wordline Decoder

This block turns a row address into a one-hot set of wordlines for a memory bank. The address is captured in a register on the rising clock edge. The registered bits are split into pairs, and each pair feeds a small 2:4 predecoder that raises exactly one of four intermediate lines. A chain of merge stages then builds the full line set. Each stage combines the line set decoded so far from the upper address bits with the next lower predecoder group, using one two-input AND per output line. The group count therefore grows fourfold at every stage, until there are 2^ADDR_W decoded lines.

A driver stage sits on every decoded line. It passes the line to the wordline output only while the bank-select input is high and the wordline-enable input is high. The enable is meant to follow the evaluate phase of the clock, so that no wordline rises while the bitlines precharge. Both gating inputs act combinationally. The address path is registered.

`ADDR_W` must be even and lie between 2 and 8. With `ADDR_W` = 2 the block reduces to a single predecoder followed by the drivers.

Top module: `rowdec_top`

## Requirements
- R1: While `bank_sel` and `wl_en` are both high, exactly one bit of `wl_out` is 1, and its index equals the registered address read as an unsigned binary number (bit i of `wl_out` is wordline i).
- R2: `addr_in` is sampled on the rising edge of `clk`. A change of `addr_in` between edges does not alter `wl_out`, and the new line appears after the next rising edge.
- R3: Each address pair decodes one-hot, with 00 giving line 0, 01 line 1, 10 line 2 and 11 line 3. Wordline i is the AND of line i/4 of the set decoded from the higher bits and line i%4 of the pair formed by the lowest two address bits. For every address, the selected index is therefore the full binary value of the address.
- R4: While `bank_sel` is low, `wl_out` is all zero, whatever the address and `wl_en`.
- R5: While `wl_en` is low, `wl_out` is all zero, whatever the address and `bank_sel`.
- R6: A synchronous active-high `rst` clears the address register to 0, so wordline 0 is the selected line during and right after reset.
- R7: `bank_sel` and `wl_en` take effect on `wl_out` in the same cycle they change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the address is captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the address register |
| addr_in | input | ADDR_W | Row address |
| bank_sel | input | 1 | Bank select; low forces all wordlines low |
| wl_en | input | 1 | Wordline enable (evaluate phase); low forces all wordlines low |
| wl_out | output | 2**ADDR_W | One-hot wordlines |

## Verification
The case of interest is a clock edge that loads a new address while the bank is deselected in that same cycle. The bench provokes it by changing `addr_in` and dropping `bank_sel` in one cycle. After the edge it expects all wordlines low, even though the register now holds a new row. It then raises `bank_sel` in mid-cycle and expects the newly loaded row to appear at once, without the old row appearing in between. A similar test drops `wl_en` just after a valid line is already up, and expects the line to fall without any clock edge.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  // number of predecoder groups for a given address width
  function automatic int n_groups(input int addr_w);
    return addr_w / 2;
  endfunction

  // number of decoded lines after merging g groups
  function automatic int lines_after(input int g);
    return 4 ** g;
  endfunction
endpackage

// File: rtl/rowdec_predec.sv
module rowdec_predec (
  input  logic [1:0] pair,
  output logic [3:0] line
);
  // 2:4 one-hot: code v raises line v
  for (genvar v = 0; v < 4; v++) begin : g_line
    localparam logic [1:0] CODE = 2'(v);
    assign line[v] = (pair[1] == CODE[1]) & (pair[0] == CODE[0]);
  end
endmodule

// File: rtl/rowdec_merge.sv
module rowdec_merge #(
  parameter int HI_W = 4
) (
  input  logic [HI_W-1:0]   hi,
  input  logic [3:0]        lo,
  output logic [HI_W*4-1:0] wl
);
  localparam int OUT_W = HI_W * 4;

  // two-input AND per output: upper-set line i/4 with lower pair line i%4
  for (genvar i = 0; i < OUT_W; i++) begin : g_and
    assign wl[i] = hi[i/4] & lo[i%4];
  end
endmodule

// File: rtl/rowdec_wldrv.sv
module rowdec_wldrv #(
  parameter int NW = 16
) (
  input  logic [NW-1:0] dec,
  input  logic          bank_sel,
  input  logic          wl_en,
  output logic [NW-1:0] wl
);
  logic gate;
  assign gate = bank_sel & wl_en;

  for (genvar i = 0; i < NW; i++) begin : g_drv
    assign wl[i] = dec[i] & gate;
  end
endmodule

// File: rtl/rowdec_top.sv
module rowdec_top #(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic                 bank_sel,
  input  logic                 wl_en,
  output logic [2**ADDR_W-1:0] wl_out
);
  import rowdec_pkg::*;

  localparam int P  = n_groups(ADDR_W);
  localparam int NW = lines_after(P);

  if ((ADDR_W % 2) != 0 || ADDR_W < 2 || ADDR_W > 8) begin : g_bad_width
    $error("rowdec_top: ADDR_W must be even and within 2..8");
  end

  // registered address
  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_in;
  end

  // predecode stage: one 2:4 per address pair, group p takes bits 2p+1:2p
  logic [3:0] pre [P];
  for (genvar p = 0; p < P; p++) begin : g_pre
    rowdec_predec u_pre (
      .pair (addr_q[2*p+1 -: 2]),
      .line (pre[p])
    );
  end

  // merge chain: stage j holds the lines decoded from the top j+1 pairs
  for (genvar j = 0; j < P; j++) begin : g_st
    localparam int W = 4 ** (j + 1);
    logic [W-1:0] lines;
    if (j == 0) begin : g_first
      assign lines = pre[P-1];
    end else begin : g_next
      rowdec_merge #(.HI_W(4 ** j)) u_merge (
        .hi (g_st[j-1].lines),
        .lo (pre[P-1-j]),
        .wl (lines)
      );
    end
  end

  logic [NW-1:0] dec;
  assign dec = g_st[P-1].lines;

  rowdec_wldrv #(.NW(NW)) u_drv (
    .dec      (dec),
    .bank_sel (bank_sel),
    .wl_en    (wl_en),
    .wl       (wl_out)
  );

  // R1: gated on, exactly the addressed line is up
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    (bank_sel && wl_en) |-> ($countones(wl_out) == 1 && wl_out[addr_q]));

  // R2: the register follows addr_in one edge later
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (addr_q == $past(addr_in)));

  // R4: deselected bank keeps every line low
  p_bank_off_r4: assert property (@(posedge clk) disable iff (rst)
    !bank_sel |-> (wl_out == '0));

  // R5: enable low keeps every line low
  p_en_off_r5: assert property (@(posedge clk) disable iff (rst)
    !wl_en |-> (wl_out == '0));

  // R6: reset returns the address to row 0
  p_reset_r6: assert property (@(posedge clk)
    rst |=> (addr_q == '0));
endmodule

// File: tb/rowdec_top_tb_top.sv
module rowdec_top_tb_top;
  localparam int AW = 4;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          bank_sel = 1'b0;
  logic          wl_en = 1'b0;
  logic [NW-1:0] wl_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rowdec_top #(.ADDR_W(AW)) dut_i (
    .clk (clk), .rst (rst), .addr_in (addr_in),
    .bank_sel (bank_sel), .wl_en (wl_en), .wl_out (wl_out)
  );

  // {addr[21:18], bank_sel[17], wl_en[16], expected[15:0]}
  localparam logic [21:0] VEC [8] = '{
    {4'd0,  1'b1, 1'b1, 16'h0001},  // R1 R3
    {4'd5,  1'b1, 1'b1, 16'h0020},  // R1 R3
    {4'd10, 1'b1, 1'b1, 16'h0400},  // R1 R3
    {4'd15, 1'b1, 1'b1, 16'h8000},  // R1 R3
    {4'd3,  1'b0, 1'b1, 16'h0000},  // R4
    {4'd12, 1'b1, 1'b0, 16'h0000},  // R5
    {4'd9,  1'b0, 1'b0, 16'h0000},  // R4 R5
    {4'd6,  1'b1, 1'b1, 16'h0040}   // R1 R3
  };

  task automatic chk(input string req, input logic [NW-1:0] act,
                     input logic [NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic bs, input logic en);
    @(negedge clk);
    addr_in  = a;
    bank_sel = bs;
    wl_en    = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R6: reset state with gates open and a nonzero address applied
    addr_in = 4'd9; bank_sel = 1'b1; wl_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", wl_out, 16'h0001);
    rst = 1'b0;

    // vector table walk
    for (int k = 0; k < 8; k++) begin
      apply(VEC[k][21:18], VEC[k][17], VEC[k][16]);
      chk("R1/R3/R4/R5 table", wl_out, VEC[k][15:0]);
    end

    // R1 R3: every address yields its own single line
    for (int a = 0; a < NW; a++) begin
      apply(AW'(a), 1'b1, 1'b1);
      chk("R1 sweep", wl_out, NW'(1) << a);
    end

    // R4: every address, bank deselected
    for (int a = 0; a < NW; a++) begin
      apply(AW'(a), 1'b0, 1'b1);
      chk("R4 sweep", wl_out, '0);
    end

    // R2: change between edges has no effect until the next edge
    apply(4'd2, 1'b1, 1'b1);
    chk("R2 before", wl_out, 16'h0004);
    addr_in = 4'd7;
    #1;
    chk("R2 no edge", wl_out, 16'h0004);
    @(posedge clk);
    @(negedge clk);
    chk("R2 after edge", wl_out, 16'h0080);

    // R7: gates act in the same cycle
    bank_sel = 1'b0; #1;
    chk("R7 bank drop", wl_out, '0);
    bank_sel = 1'b1; #1;
    chk("R7 bank raise", wl_out, 16'h0080);
    wl_en = 1'b0; #1;
    chk("R7 en drop", wl_out, '0);
    wl_en = 1'b1; #1;
    chk("R7 en raise", wl_out, 16'h0080);

    // same cycle: new address loaded while the bank is deselected
    apply(4'd11, 1'b0, 1'b1);
    chk("R4 load while off", wl_out, '0);
    bank_sel = 1'b1; #1;
    chk("R7 new row after select", wl_out, 16'h0800);

    // R6: reset mid-run returns to row 0
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R6 mid-run", wl_out, 16'h0001);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule